// File: doc/BRIEF.md
# Audio Coprocessor Bus Register Decoder

This block sits between a small audio coprocessor core and the resources on that core's 16-bit address, 8-bit data bus. It turns each bus access into request strobes for a 64 KiB work RAM, a 64-byte boot ROM and a 128-entry sound-generator register file. It also decodes a page of sixteen I/O registers at 0x00F0–0x00FF. Those registers hold the test and control settings, an indirect index into the sound-generator file, two scratch bytes, the timer targets and counters, and four mailbox ports shared with a host CPU.

The boot ROM covers the top 64 bytes of the address space for reads only. Every write, including a write to an I/O register or to the ROM range, is also offered to the RAM at the same address, as long as the RAM write rules allow it. A read is accepted in one cycle and its data is returned in the next cycle. Writes take effect at the clock edge that closes the request cycle.

Top module: `acp_bus_decoder`

## Requirements
- R1: After reset the boot-ROM overlay is on, RAM writes are allowed, RAM is not disabled, clock and timer speed fields are 0, both timer enable/halt flags are 0, all three timer run bits are 0, and all coprocessor-to-host mailbox bytes are 0.
- R2: While the overlay is on, a read of 0xFFC0–0xFFFF returns the ROM byte addressed by bus address bits 5:0 and issues no RAM request. While the overlay is off, such a read returns the RAM byte.
- R3: Every bus write, whatever its address, raises ram_req and ram_we in the same cycle exactly when the RAM-writable bit is 1 and the RAM-disable bit is 0.
- R4: While RAM-disable is 1, a read of a RAM-backed address returns 0x5A and raises no RAM request. I/O registers stay readable.
- R5: Reads of 0x00F0, 0x00F1 and 0x00FA–0x00FC return 0x00. A write to 0x00FA/0x00FB/0x00FC pulses tmr_tgt_we bit 0/1/2 and carries the data on tmr_tgt_data. Writes to 0x00FD–0x00FF change no register and no timer output.
- R6: 0x00F2 is a readable 8-bit index. An access at 0x00F3 reaches sound-generator entry index[6:0]. A write at 0x00F3 is dropped (no snd_req, no snd_we) when index bit 7 is 1, while reads still go through.
- R7: A write to 0x00F0 with proc_p_flag low loads clock speed from bits 7:6, timer speed from 5:4, timer enable from 3, RAM-disable from 2, RAM-writable from 1 and timer halt from 0. With proc_p_flag high the write changes none of these.
- R8: A write to 0x00F1 loads the overlay enable from bit 7 and the timer run bits 2:0. Bit 5 clears host-to-coprocessor ports 2 and 3, and bit 4 clears ports 0 and 1. tmr_restart pulses in that cycle for each run bit that goes from 0 to 1.
- R9: 0x00F8 and 0x00F9 are independent 8-bit read/write scratch bytes.
- R10: Reads of 0x00F4–0x00F7 return the byte the host last wrote to port 0–3. Coprocessor writes there update the matching byte of mbox_to_host (port n at bits 8n+7:8n).
- R11: bus_rvalid is 1 in the cycle after each accepted read and 0 after any other cycle. Strobes toward RAM, ROM, sound generator and timers appear in the request cycle itself.
- R12: A read of 0x00FD/0x00FE/0x00FF returns the 4-bit count of timer 0/1/2 zero-extended and pulses tmr_cnt_rd bit 0/1/2 in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| proc_p_flag | input | 1 | Processor P flag; blocks test-register writes |
| bus_rdata | output | 8 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Read data valid |
| ram_req | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after ram_req |
| rom_addr | output | 6 | Boot-ROM index |
| rom_rdata | input | 8 | Boot-ROM data, one cycle after the address |
| snd_req | output | 1 | Sound-generator register access strobe |
| snd_we | output | 1 | Sound-generator register write strobe |
| snd_addr | output | 7 | Sound-generator register index |
| snd_wdata | output | 8 | Sound-generator write data |
| snd_rdata | input | 8 | Sound-generator read data, one cycle after snd_req |
| host_we | input | 1 | Host write to a mailbox port |
| host_port | input | 2 | Host mailbox port number |
| host_wdata | input | 8 | Host mailbox write data |
| mbox_to_host | output | 32 | Coprocessor-to-host mailbox bytes, port n at 8n+7:8n |
| clk_speed | output | 2 | Clock speed field |
| tmr_speed | output | 2 | Timer speed field |
| tmr_global_en | output | 1 | Timer enable bit |
| tmr_halt | output | 1 | Timer halt bit |
| tmr_run | output | 3 | Per-timer run enables |
| tmr_restart | output | 3 | Per-timer restart pulse on a 0-to-1 run edge |
| tmr_tgt_we | output | 3 | Per-timer target write strobe |
| tmr_tgt_data | output | 8 | Timer target data |
| tmr_cnt_rd | output | 3 | Per-timer counter read strobe |
| tmr_cnt | input | 12 | Timer counts, timer n at 4n+3:4n |

## Verification
Each access has three kinds of result, and each is due at a different time. The RAM, sound-generator and timer strobes are combinational and are due in the request cycle, so the bench samples them 1 ns after it drives the inputs at the falling edge. Read data and bus_rvalid go through one register and are due in the next cycle, so the bench samples them 2 ns after the rising edge that closes the request. Register and mailbox state written by an access is also visible after that same edge. The bench's behavioural model updates only after the edge, so the values it predicts for a cycle always come from the state that was held during that cycle.

// File: rtl/acp_pkg.sv
package acp_pkg;

    localparam int NUM_TMR      = 3;
    localparam int CTL_ROM_BIT  = 7;
    localparam int CTL_CLR_HI   = 5;
    localparam int CTL_CLR_LO   = 4;

    typedef enum logic [3:0] {
        RG_MEM, RG_ROM, RG_TEST, RG_CTRL, RG_IDX, RG_WIN,
        RG_MBOX, RG_SCR0, RG_SCR1, RG_TGT, RG_CNT
    } region_e;

    typedef enum logic [1:0] {
        SRC_MEM, SRC_ROM, SRC_SND, SRC_REG
    } src_e;

    // field order equals the bit order of the test register write
    typedef struct packed {
        logic [1:0] clk_spd;
        logic [1:0] tmr_spd;
        logic       tmr_en;
        logic       ram_dis;
        logic       ram_wr;
        logic       tmr_dis;
    } test_cfg_t;

endpackage

// File: rtl/acp_addr_decode.sv
module acp_addr_decode
    import acp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int ROM_AW  = 6,
    parameter int IO_BASE = 'h00F0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_en,
    output region_e           region,
    output logic [1:0]        sel
);
    localparam int TAG_W = ADDR_W - 4;

    logic io_hit;
    logic top_hit;

    assign io_hit  = (addr[ADDR_W-1:4] == TAG_W'(IO_BASE >> 4));
    assign top_hit = &addr[ADDR_W-1:ROM_AW];

    always_comb begin
        region = RG_MEM;
        sel    = addr[1:0];
        if (io_hit) begin
            case (addr[3:0])
                4'h0: region = RG_TEST;
                4'h1: region = RG_CTRL;
                4'h2: region = RG_IDX;
                4'h3: region = RG_WIN;
                4'h4, 4'h5, 4'h6, 4'h7: region = RG_MBOX;
                4'h8: region = RG_SCR0;
                4'h9: region = RG_SCR1;
                4'hA, 4'hB, 4'hC: begin
                    region = RG_TGT;
                    sel    = addr[1:0] - 2'd2;
                end
                default: begin
                    region = RG_CNT;
                    sel    = addr[1:0] - 2'd1;
                end
            endcase
        end else if (rom_en && top_hit) begin
            region = RG_ROM;
        end
    end

endmodule

// File: rtl/acp_ctrl_regs.sv
module acp_ctrl_regs
    import acp_pkg::*;
#(
    parameter int   DATA_W     = 8,
    parameter logic ROM_EN_RST = 1'b1,
    parameter logic RAM_WR_RST = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  region_e             region,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                p_flag,
    output test_cfg_t           cfg,
    output logic                rom_en,
    output logic [NUM_TMR-1:0]  run,
    output logic [NUM_TMR-1:0]  restart,
    output logic                clr_lo,
    output logic                clr_hi,
    output logic [DATA_W-1:0]   idx,
    output logic [DATA_W-1:0]   scr0,
    output logic [DATA_W-1:0]   scr1
);
    typedef struct packed {
        test_cfg_t            cfg;
        logic                 rom_en;
        logic [NUM_TMR-1:0]   run;
        logic [DATA_W-1:0]    idx;
        logic [DATA_W-1:0]    scr0;
        logic [DATA_W-1:0]    scr1;
    } state_t;

    state_t st_d, st_q;
    logic   ctl_wr;

    assign ctl_wr = wr_en && (region == RG_CTRL);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (region)
                RG_TEST: if (!p_flag) st_d.cfg = test_cfg_t'(wdata[7:0]);
                RG_CTRL: begin
                    st_d.rom_en = wdata[CTL_ROM_BIT];
                    st_d.run    = wdata[NUM_TMR-1:0];
                end
                RG_IDX:  st_d.idx  = wdata;
                RG_SCR0: st_d.scr0 = wdata;
                RG_SCR1: st_d.scr1 = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.rom_en     <= ROM_EN_RST;
            st_q.cfg.ram_wr <= RAM_WR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign restart = ctl_wr ? (wdata[NUM_TMR-1:0] & ~st_q.run) : '0;
    assign clr_hi  = ctl_wr && wdata[CTL_CLR_HI];
    assign clr_lo  = ctl_wr && wdata[CTL_CLR_LO];
    assign cfg     = st_q.cfg;
    assign rom_en  = st_q.rom_en;
    assign run     = st_q.run;
    assign idx     = st_q.idx;
    assign scr0    = st_q.scr0;
    assign scr1    = st_q.scr1;

endmodule

// File: rtl/acp_mailbox.sv
module acp_mailbox #(
    parameter int N_PORT = 4,
    parameter int DATA_W = 8,
    localparam int PW    = $clog2(N_PORT),
    localparam int NPAIR = N_PORT / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_we,
    input  logic [PW-1:0]              host_port,
    input  logic [DATA_W-1:0]          host_wdata,
    input  logic                       cpu_we,
    input  logic [PW-1:0]              cpu_port,
    input  logic [DATA_W-1:0]          cpu_wdata,
    input  logic [NPAIR-1:0]           clr_pair,
    output logic [N_PORT*DATA_W-1:0]   from_host,
    output logic [N_PORT*DATA_W-1:0]   to_host
);
    logic [DATA_W-1:0] in_d  [N_PORT];
    logic [DATA_W-1:0] in_q  [N_PORT];
    logic [DATA_W-1:0] out_d [N_PORT];
    logic [DATA_W-1:0] out_q [N_PORT];

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        // a pair clear is applied after a same-cycle host write
        assign in_d[p]  = clr_pair[p/2] ? '0 :
                          (host_we && host_port == PW'(p)) ? host_wdata : in_q[p];
        assign out_d[p] = (cpu_we && cpu_port == PW'(p)) ? cpu_wdata : out_q[p];
        assign from_host[p*DATA_W +: DATA_W] = in_q[p];
        assign to_host[p*DATA_W +: DATA_W]   = out_q[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PORT; i++) begin
                in_q[i]  <= '0;
                out_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_PORT; i++) begin
                in_q[i]  <= in_d[i];
                out_q[i] <= out_d[i];
            end
        end
    end

endmodule

// File: rtl/acp_bus_decoder.sv
module acp_bus_decoder
    import acp_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          DATA_W       = 8,
    parameter int          ROM_AW       = 6,
    parameter int          SND_AW       = 7,
    parameter int          N_MBOX       = 4,
    parameter int          CNT_W        = 4,
    parameter logic [7:0]  RAM_OFF_BYTE = 8'h5A,
    localparam int         PW           = $clog2(N_MBOX)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_req,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        proc_p_flag,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        bus_rvalid,
    output logic                        ram_req,
    output logic                        ram_we,
    output logic [ADDR_W-1:0]           ram_addr,
    output logic [DATA_W-1:0]           ram_wdata,
    input  logic [DATA_W-1:0]           ram_rdata,
    output logic [ROM_AW-1:0]           rom_addr,
    input  logic [DATA_W-1:0]           rom_rdata,
    output logic                        snd_req,
    output logic                        snd_we,
    output logic [SND_AW-1:0]           snd_addr,
    output logic [DATA_W-1:0]           snd_wdata,
    input  logic [DATA_W-1:0]           snd_rdata,
    input  logic                        host_we,
    input  logic [PW-1:0]               host_port,
    input  logic [DATA_W-1:0]           host_wdata,
    output logic [N_MBOX*DATA_W-1:0]    mbox_to_host,
    output logic [1:0]                  clk_speed,
    output logic [1:0]                  tmr_speed,
    output logic                        tmr_global_en,
    output logic                        tmr_halt,
    output logic [NUM_TMR-1:0]          tmr_run,
    output logic [NUM_TMR-1:0]          tmr_restart,
    output logic [NUM_TMR-1:0]          tmr_tgt_we,
    output logic [DATA_W-1:0]           tmr_tgt_data,
    output logic [NUM_TMR-1:0]          tmr_cnt_rd,
    input  logic [NUM_TMR*CNT_W-1:0]    tmr_cnt
);
    typedef struct packed {
        logic               valid;
        src_e               src;
        logic [DATA_W-1:0]  data;
    } rd_t;

    region_e                  region;
    logic [1:0]               sel;
    logic                     wr, rd, ram_wr_ok, win_wr_ok;
    test_cfg_t                cfg;
    logic                     rom_en, clr_lo, clr_hi;
    logic [DATA_W-1:0]        idx, scr0, scr1;
    logic [N_MBOX*DATA_W-1:0] from_host;
    rd_t                      rd_d, rd_q;

    assign wr = bus_req && bus_we;
    assign rd = bus_req && !bus_we;

    acp_addr_decode #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) dec_i (
        .addr   (bus_addr),
        .rom_en (rom_en),
        .region (region),
        .sel    (sel)
    );

    acp_ctrl_regs #(.DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr),
        .region  (region),
        .wdata   (bus_wdata),
        .p_flag  (proc_p_flag),
        .cfg     (cfg),
        .rom_en  (rom_en),
        .run     (tmr_run),
        .restart (tmr_restart),
        .clr_lo  (clr_lo),
        .clr_hi  (clr_hi),
        .idx     (idx),
        .scr0    (scr0),
        .scr1    (scr1)
    );

    acp_mailbox #(.N_PORT(N_MBOX), .DATA_W(DATA_W)) mbox_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_port  (host_port),
        .host_wdata (host_wdata),
        .cpu_we     (wr && region == RG_MBOX),
        .cpu_port   (sel[PW-1:0]),
        .cpu_wdata  (bus_wdata),
        .clr_pair   ({clr_hi, clr_lo}),
        .from_host  (from_host),
        .to_host    (mbox_to_host)
    );

    // request-cycle strobes
    assign ram_wr_ok = cfg.ram_wr && !cfg.ram_dis;
    assign win_wr_ok = !idx[DATA_W-1];
    assign ram_we    = wr && ram_wr_ok;
    assign ram_req   = ram_we || (rd && region == RG_MEM && !cfg.ram_dis);
    assign ram_addr  = bus_addr;
    assign ram_wdata = bus_wdata;
    assign rom_addr  = bus_addr[ROM_AW-1:0];
    assign snd_we    = wr && region == RG_WIN && win_wr_ok;
    assign snd_req   = snd_we || (rd && region == RG_WIN);
    assign snd_addr  = idx[SND_AW-1:0];
    assign snd_wdata = bus_wdata;

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        assign tmr_tgt_we[t] = wr && region == RG_TGT && sel == 2'(t);
        assign tmr_cnt_rd[t] = rd && region == RG_CNT && sel == 2'(t);
    end
    assign tmr_tgt_data  = bus_wdata;

    assign clk_speed     = cfg.clk_spd;
    assign tmr_speed     = cfg.tmr_spd;
    assign tmr_global_en = cfg.tmr_en;
    assign tmr_halt      = cfg.tmr_dis;

    // read-return stage: choose the source in the request cycle, deliver next cycle
    always_comb begin
        rd_d.valid = rd;
        rd_d.src   = SRC_REG;
        rd_d.data  = '0;
        case (region)
            RG_MEM: begin
                if (cfg.ram_dis) rd_d.data = DATA_W'(RAM_OFF_BYTE);
                else             rd_d.src  = SRC_MEM;
            end
            RG_ROM:  rd_d.src  = SRC_ROM;
            RG_WIN:  rd_d.src  = SRC_SND;
            RG_IDX:  rd_d.data = idx;
            RG_MBOX: rd_d.data = from_host[sel*DATA_W +: DATA_W];
            RG_SCR0: rd_d.data = scr0;
            RG_SCR1: rd_d.data = scr1;
            RG_CNT:  rd_d.data = DATA_W'(tmr_cnt[sel*CNT_W +: CNT_W]);
            default: rd_d.data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    always_comb begin
        bus_rvalid = rd_q.valid;
        bus_rdata  = '0;
        if (rd_q.valid) begin
            case (rd_q.src)
                SRC_MEM: bus_rdata = ram_rdata;
                SRC_ROM: bus_rdata = rom_rdata;
                SRC_SND: bus_rdata = snd_rdata;
                default: bus_rdata = rd_q.data;
            endcase
        end
    end

endmodule

// File: rtl/acp_bus_decoder_chk.sv
module acp_bus_decoder_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              proc_p_flag,
    input logic              bus_rvalid,
    input logic              ram_req,
    input logic              ram_we,
    input logic              snd_we,
    input logic [1:0]        clk_speed,
    input logic [1:0]        tmr_speed,
    input logic [2:0]        tmr_run,
    input logic [2:0]        tmr_restart,
    input logic [2:0]        tmr_cnt_rd
);
    logic is_rd, is_wr, io_page;
    assign is_rd   = bus_req && !bus_we;
    assign is_wr   = bus_req && bus_we;
    assign io_page = (bus_addr[ADDR_W-1:4] == (ADDR_W-4)'('h00F));

    a_r11_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> bus_rvalid);
    a_r11_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rd |=> !bus_rvalid);
    a_r3_we_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (is_wr && ram_req));
    a_r4_no_ram_read_on_io: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && io_page) |-> !ram_req);
    a_r6_snd_write_at_window: assert property (@(posedge clk) disable iff (!rst_n)
        snd_we |-> (is_wr && bus_addr == ADDR_W'('h00F3)));
    a_r7_p_flag_blocks_test: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && bus_addr == ADDR_W'('h00F0) && proc_p_flag)
            |=> ($stable(clk_speed) && $stable(tmr_speed)));
    a_r8_restart_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_restart) |=> ((tmr_run & $past(tmr_restart)) == $past(tmr_restart)));
    a_r12_cnt_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_cnt_rd));
    a_r5_cnt_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && io_page && bus_addr[3:0] >= 4'hD)
            |=> ($stable(tmr_run) && $stable(clk_speed)));

endmodule

bind acp_bus_decoder acp_bus_decoder_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .proc_p_flag (proc_p_flag),
    .bus_rvalid  (bus_rvalid),
    .ram_req     (ram_req),
    .ram_we      (ram_we),
    .snd_we      (snd_we),
    .clk_speed   (clk_speed),
    .tmr_speed   (tmr_speed),
    .tmr_run     (tmr_run),
    .tmr_restart (tmr_restart),
    .tmr_cnt_rd  (tmr_cnt_rd)
);

// File: tb/acp_bus_decoder_tb_top.sv
`timescale 1ns/1ps
module acp_bus_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_we = 0, proc_p_flag = 0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic        ram_req, ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;
    logic [5:0]  rom_addr;
    logic [7:0]  rom_rdata;
    logic        snd_req, snd_we;
    logic [6:0]  snd_addr;
    logic [7:0]  snd_wdata, snd_rdata;
    logic        host_we = 0;
    logic [1:0]  host_port = '0;
    logic [7:0]  host_wdata = '0;
    logic [31:0] mbox_to_host;
    logic [1:0]  clk_speed, tmr_speed;
    logic        tmr_global_en, tmr_halt;
    logic [2:0]  tmr_run, tmr_restart, tmr_tgt_we, tmr_cnt_rd;
    logic [7:0]  tmr_tgt_data;
    logic [11:0] tmr_cnt = 12'h963;

    always #4 clk = ~clk;

    acp_bus_decoder dut_i (.*);

    // synchronous memory models: data follows the latched address
    logic [15:0] ram_a_l = '0;
    logic [5:0]  rom_a_l = '0;
    logic [6:0]  snd_a_l = '0;
    always @(posedge clk) begin
        ram_a_l <= ram_addr;
        rom_a_l <= rom_addr;
        snd_a_l <= snd_addr;
    end
    function automatic logic [7:0] ram_f(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] rom_f(input logic [5:0] a);
        return {2'b10, a};
    endfunction
    function automatic logic [7:0] snd_f(input logic [6:0] a);
        return {1'b1, a} ^ 8'h0F;
    endfunction
    assign ram_rdata = ram_f(ram_a_l);
    assign rom_rdata = rom_f(rom_a_l);
    assign snd_rdata = snd_f(snd_a_l);

    // behavioural model state
    logic       m_rom_en, m_ram_wr, m_ram_dis, m_tmr_en, m_tmr_dis;
    logic [1:0] m_clk, m_tspd;
    logic [2:0] m_run;
    logic [7:0] m_idx, m_s8, m_s9;
    logic [7:0] m_from [4];
    logic [7:0] m_to   [4];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (a[15:4] == 12'h00F) begin
            case (a[3:0])
                4'h2: return m_idx;
                4'h3: return snd_f(m_idx[6:0]);
                4'h4, 4'h5, 4'h6, 4'h7: return m_from[a[1:0]];
                4'h8: return m_s8;
                4'h9: return m_s9;
                4'hD: return {4'h0, tmr_cnt[3:0]};
                4'hE: return {4'h0, tmr_cnt[7:4]};
                4'hF: return {4'h0, tmr_cnt[11:8]};
                default: return 8'h00;
            endcase
        end
        if (m_rom_en && a >= 16'hFFC0) return rom_f(a[5:0]);
        if (m_ram_dis) return 8'h5A;
        return ram_f(a);
    endfunction

    task automatic check_state();
        chk("R7 clk_speed", clk_speed, m_clk);
        chk("R7 tmr_speed", tmr_speed, m_tspd);
        chk("R7 tmr_global_en", tmr_global_en, m_tmr_en);
        chk("R7 tmr_halt", tmr_halt, m_tmr_dis);
        chk("R8 tmr_run", tmr_run, m_run);
        chk("R10 mbox_to_host", mbox_to_host,
            {m_to[3], m_to[2], m_to[1], m_to[0]});
    endtask

    task automatic op(input bit we, input logic [15:0] a, input logic [7:0] d,
                      input bit p, input string tag);
        bit        io;
        logic      e_ram_req, e_snd_we, e_snd_req;
        logic [2:0] e_rst, e_cnt, e_tgt;
        logic [7:0] e_rd;
        io = (a[15:4] == 12'h00F);
        e_ram_req = we ? (m_ram_wr && !m_ram_dis)
                       : (!io && !(m_rom_en && a >= 16'hFFC0) && !m_ram_dis);
        e_snd_we  = we && a == 16'h00F3 && !m_idx[7];
        e_snd_req = (a == 16'h00F3) && (!we || !m_idx[7]);
        e_rst = (we && a == 16'h00F1) ? (d[2:0] & ~m_run) : 3'b000;
        e_cnt = (!we && io && a[3:0] >= 4'hD) ? 3'(1 << (a[3:0] - 4'hD)) : 3'b000;
        e_tgt = (we && io && a[3:0] >= 4'hA && a[3:0] <= 4'hC)
                ? 3'(1 << (a[3:0] - 4'hA)) : 3'b000;
        e_rd  = exp_read(a);

        @(negedge clk);
        bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d; proc_p_flag = p;
        #1;
        chk("R4 ram_req", ram_req, e_ram_req);
        chk("R3 ram_we", ram_we, we && e_ram_req);
        chk("R6 snd_we", snd_we, e_snd_we);
        chk("R6 snd_req", snd_req, e_snd_req);
        if (e_snd_req) chk("R6 snd_addr", snd_addr, m_idx[6:0]);
        chk("R8 tmr_restart", tmr_restart, e_rst);
        chk("R12 tmr_cnt_rd", tmr_cnt_rd, e_cnt);
        chk("R5 tmr_tgt_we", tmr_tgt_we, e_tgt);
        if (e_tgt != 0) chk("R5 tmr_tgt_data", tmr_tgt_data, d);
        @(posedge clk);
        #2;
        bus_req = 0; bus_we = 0; proc_p_flag = 0;
        chk("R11 rvalid", bus_rvalid, !we);
        if (!we) chk(tag, bus_rdata, e_rd);
        if (we && io) begin
            case (a[3:0])
                4'h0: if (!p) begin
                    {m_clk, m_tspd, m_tmr_en, m_ram_dis, m_ram_wr, m_tmr_dis} = d;
                end
                4'h1: begin
                    m_rom_en = d[7];
                    m_run    = d[2:0];
                    if (d[5]) begin m_from[2] = 0; m_from[3] = 0; end
                    if (d[4]) begin m_from[0] = 0; m_from[1] = 0; end
                end
                4'h2: m_idx = d;
                4'h4, 4'h5, 4'h6, 4'h7: m_to[a[1:0]] = d;
                4'h8: m_s8 = d;
                4'h9: m_s9 = d;
                default: ;
            endcase
        end
        check_state();
    endtask

    task automatic host_write(input logic [1:0] port, input logic [7:0] d);
        @(negedge clk);
        host_we = 1; host_port = port; host_wdata = d;
        @(posedge clk);
        #2;
        host_we = 0;
        m_from[port] = d;
    endtask

    initial begin
        m_rom_en = 1; m_ram_wr = 1; m_ram_dis = 0; m_tmr_en = 0; m_tmr_dis = 0;
        m_clk = 0; m_tspd = 0; m_run = 0; m_idx = 0; m_s8 = 0; m_s9 = 0;
        for (int i = 0; i < 4; i++) begin m_from[i] = 0; m_to[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 rvalid low", bus_rvalid, 1'b0);
        check_state();

        op(0, 16'hFFC5, 8'h00, 0, "R1 R2 overlay on after reset");
        op(1, 16'hFFC5, 8'h11, 0, "R3");
        op(0, 16'h1234, 8'h00, 0, "R2 plain RAM read");
        op(1, 16'h00F1, 8'h00, 0, "R8");
        op(0, 16'hFFC5, 8'h00, 0, "R2 overlay off reads RAM");
        op(0, 16'h00F0, 8'h00, 0, "R5 test reg reads 0");
        op(0, 16'h00F1, 8'h00, 0, "R5 ctrl reg reads 0");
        op(1, 16'h00FA, 8'h33, 0, "R5");
        op(0, 16'h00FC, 8'h00, 0, "R5 target reads 0");

        op(1, 16'h00F2, 8'h05, 0, "R6");
        op(1, 16'h00F3, 8'h77, 0, "R6");
        op(0, 16'h00F3, 8'h00, 0, "R6 window read");
        op(0, 16'h00F2, 8'h00, 0, "R6 index readback");
        op(1, 16'h00F2, 8'h85, 0, "R6");
        op(1, 16'h00F3, 8'h99, 0, "R6");
        op(0, 16'h00F3, 8'h00, 0, "R6 mirror read");

        op(1, 16'h00F8, 8'hC3, 0, "R9");
        op(1, 16'h00F9, 8'h3C, 0, "R9");
        op(0, 16'h00F8, 8'h00, 0, "R9 scratch 0");
        op(0, 16'h00F9, 8'h00, 0, "R9 scratch 1");

        host_write(2'd0, 8'hA1);
        host_write(2'd3, 8'hB2);
        host_write(2'd2, 8'h5E);
        op(0, 16'h00F4, 8'h00, 0, "R10 port 0");
        op(0, 16'h00F7, 8'h00, 0, "R10 port 3");
        op(1, 16'h00F5, 8'h66, 0, "R10");
        op(1, 16'h00F6, 8'h77, 0, "R10");

        op(1, 16'h00F1, 8'h20, 0, "R8");
        op(0, 16'h00F7, 8'h00, 0, "R8 high pair cleared");
        op(0, 16'h00F4, 8'h00, 0, "R8 low pair kept");
        op(1, 16'h00F1, 8'h10, 0, "R8");
        op(0, 16'h00F4, 8'h00, 0, "R8 low pair cleared");
        op(1, 16'h00F1, 8'h87, 0, "R8");
        op(1, 16'h00F1, 8'h85, 0, "R8");
        op(1, 16'h00F1, 8'h87, 0, "R8");

        op(0, 16'h00FD, 8'h00, 0, "R12 count 0");
        op(0, 16'h00FE, 8'h00, 0, "R12 count 1");
        op(0, 16'h00FF, 8'h00, 0, "R12 count 2");
        op(1, 16'h00FE, 8'hFF, 0, "R5");
        op(0, 16'h00FE, 8'h00, 0, "R5 count write ignored");

        op(1, 16'h00F0, 8'hD6, 1, "R7");
        op(1, 16'h00F0, 8'hD6, 0, "R7");
        op(0, 16'h1234, 8'h00, 0, "R4 RAM disabled reads 5A");
        op(1, 16'h1234, 8'h55, 0, "R4");
        op(0, 16'h00F8, 8'h00, 0, "R4 io readable while disabled");
        op(0, 16'hFFC1, 8'h00, 0, "R2 overlay while RAM disabled");
        op(1, 16'h00F0, 8'h09, 0, "R7");
        op(1, 16'h1234, 8'h01, 0, "R3");
        op(0, 16'h1234, 8'h00, 0, "R4 reads resume");
        op(1, 16'h00F0, 8'h02, 0, "R7");
        op(1, 16'hFFF0, 8'h42, 0, "R3");
        op(1, 16'h00F8, 8'h42, 0, "R3");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule